// File: doc/BRIEF.md
# Pulse-Gated Dual Event Counter

This block compares an unknown signal against a once-per-second timing reference. It runs two upward counters side by side. The event counter advances on every rising edge of the unknown input. It is built from a low half and a high half, and an overflow extension sits above the high half. The reference counter advances on every system clock. Both counters run freely and are never cleared by a capture. When an accepted rising edge of the timing pulse arrives, both counters are latched in the same clock cycle. Each path keeps its own sequence number.

The timing pulse first passes through a digital filter. The filter takes one sample every `SAMPLE_DIV` clocks and changes its level only after `FILT_N` consecutive samples that differ from the current level. A capture is made only on a low-to-high change of the filtered level. For each capture the block offers two records on a valid/ready stream, one record per path. Records are offered for a single cycle and the stream has no backpressure. Software further down the line works out frequency from the count differences between successive records. The unknown input must toggle slower than half the system clock, and both inputs arrive already synchronised.

Top module: `gated_dual_counter`

## Requirements
- R1: Every rising edge of `sig_in` advances the event low half by one. When the low half wraps from all-ones to zero, the high half advances by one in the same step. The record count field, bits [2*HALF_W-1:0], holds {high half, low half}.
- R2: When both event halves wrap together, the event overflow extension advances by one. It is reported in record bits [2*HALF_W+WRAP_W-1:2*HALF_W].
- R3: The reference counter advances by one on every clock, and its overflow extension advances on each full wrap. Between two captures, the change in the reference {extension, count} equals the spacing of the pulse edges in clocks.
- R4: The two halves of a capture are taken from the same cycle. A captured event value is never torn, so it lies between the edge totals seen before and after the pulse, even when edges arrive while the capture happens.
- R5: Each path has its own sequence number in the top SEQ_W record bits. The first record after reset carries 1, and each accepted pulse adds one, including pulses whose records were dropped.
- R6: A pulse edge is accepted only after `FILT_N` consecutive samples, taken every `SAMPLE_DIV` clocks, all show the new level. Shorter pulses produce no record.
- R7: Only the rising edge of the filtered pulse captures. Each pulse yields exactly one pair of records, and the falling edge yields none.
- R8: The event record (`rec_path` = 0) is offered first. The reference record (`rec_path` = 1) is offered on the next cycle. Each is valid for one cycle only.
- R9: A record offered while `rec_ready` is low is dropped and `overrun` is set. `overrun` stays set until reset.
- R10: Reset clears all counters, overflow extensions, sequence numbers and `overrun`, and holds `rec_valid` low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low reset; asserts at once and releases in step with the clock |
| sig_in | input | 1 | Synchronised unknown signal whose rising edges are counted |
| pulse_in | input | 1 | Synchronised once-per-second timing pulse |
| rec_ready | input | 1 | Sink accepts the offered record |
| rec_valid | output | 1 | A record is offered this cycle |
| rec_path | output | 1 | 0 = event record, 1 = reference record |
| rec_data | output | 2*HALF_W+WRAP_W+SEQ_W | {sequence, overflow extension, count} |
| overrun | output | 1 | Sticky: a record was offered while not ready |

## Verification
The main stimulus is a series of pulses with a different number of unknown-signal edges before each one. The patterns include none, one, a count that lands exactly on a low-half boundary, and runs long enough to carry through the high half into the extension. Comparing each record with the running total distinguishes a missing carry between the halves from a missing extension step. Fixed pulse spacing shows whether the reference path counts every clock. Toggling the unknown input straight through a capture exposes torn captures. Short pulses test filter rejection. Holding `rec_ready` low tests dropping and the sticky flag, and a mid-run reset tests that the sequence restarts at 1.

// File: rtl/pdc_pkg.sv
package pdc_pkg;
  typedef enum logic {
    PATH_EVT = 1'b0,
    PATH_REF = 1'b1
  } path_e;

  localparam int unsigned NUM_PATHS = 2;
endpackage

// File: rtl/pdc_pulse_filter.sv
module pdc_pulse_filter #(
  parameter int unsigned SAMPLE_DIV = 4,
  parameter int unsigned FILT_N     = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic pulse_in,
  output logic rise_o
);
  localparam int unsigned DIV_W = (SAMPLE_DIV > 1) ? $clog2(SAMPLE_DIV) : 1;
  localparam int unsigned RUN_W = $clog2(FILT_N + 1);
  localparam logic [DIV_W-1:0] DIV_LAST = DIV_W'(SAMPLE_DIV - 1);
  localparam logic [RUN_W-1:0] RUN_LAST = RUN_W'(FILT_N - 1);

  logic [DIV_W-1:0] div_q, div_d;
  logic [RUN_W-1:0] run_q, run_d;
  logic             lvl_q, lvl_d;
  logic             rise_q, rise_d;
  logic             tick;

  always_comb begin
    tick   = (div_q == DIV_LAST);
    div_d  = tick ? '0 : div_q + 1'b1;
    run_d  = run_q;
    lvl_d  = lvl_q;
    rise_d = 1'b0;
    if (tick) begin
      if (pulse_in == lvl_q) begin
        run_d = '0;
      end else if (run_q == RUN_LAST) begin
        run_d  = '0;
        lvl_d  = pulse_in;
        rise_d = pulse_in;
      end else begin
        run_d = run_q + 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      div_q  <= '0;
      run_q  <= '0;
      lvl_q  <= 1'b0;
      rise_q <= 1'b0;
    end else begin
      div_q  <= div_d;
      run_q  <= run_d;
      lvl_q  <= lvl_d;
      rise_q <= rise_d;
    end
  end

  assign rise_o = rise_q;

  // R7: a capture strobe never lasts more than one cycle
  p_rise_single_r7: assert property (@(posedge clk) disable iff (!rst_n)
    rise_q |=> !rise_q);

  // R6: the filtered level only moves on a sample tick
  p_level_on_tick_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !tick |=> $stable(lvl_q));
endmodule

// File: rtl/pdc_cascade_counter.sv
module pdc_cascade_counter #(
  parameter int unsigned HALF_W = 16,
  parameter int unsigned WRAP_W = 16
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  inc_i,
  output logic [2*HALF_W-1:0]   cnt_o,
  output logic [WRAP_W-1:0]     wrap_o
);
  logic [HALF_W-1:0] lo_q, lo_d;
  logic [HALF_W-1:0] hi_q, hi_d;
  logic [WRAP_W-1:0] ext_q, ext_d;
  logic              lo_full, hi_full;

  always_comb begin
    lo_full = &lo_q;
    hi_full = &hi_q;
    lo_d    = lo_q;
    hi_d    = hi_q;
    ext_d   = ext_q;
    if (inc_i) begin
      lo_d = lo_q + 1'b1;
      if (lo_full) begin
        hi_d = hi_q + 1'b1;
        if (hi_full) begin
          ext_d = ext_q + 1'b1;
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lo_q  <= '0;
      hi_q  <= '0;
      ext_q <= '0;
    end else begin
      lo_q  <= lo_d;
      hi_q  <= hi_d;
      ext_q <= ext_d;
    end
  end

  assign cnt_o  = {hi_q, lo_q};
  assign wrap_o = ext_q;

  // R1: a low-half wrap carries into the high half on the same step
  p_half_carry_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (inc_i && lo_full) |=> (lo_q == '0) && (hi_q == HALF_W'($past(hi_q) + 1'b1)));

  // R1: without an increment nothing moves
  p_hold_idle_r1: assert property (@(posedge clk) disable iff (!rst_n)
    !inc_i |=> $stable(lo_q) && $stable(hi_q) && $stable(ext_q));

  // R2: full wrap of both halves advances the extension
  p_ext_step_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (inc_i && lo_full && hi_full) |=> (ext_q == WRAP_W'($past(ext_q) + 1'b1)));
endmodule

// File: rtl/pdc_capture_path.sv
module pdc_capture_path #(
  parameter int unsigned HALF_W = 16,
  parameter int unsigned WRAP_W = 16,
  parameter int unsigned SEQ_W  = 16
) (
  input  logic                                clk,
  input  logic                                rst_n,
  input  logic                                inc_i,
  input  logic                                cap_i,
  output logic [2*HALF_W+WRAP_W+SEQ_W-1:0]    rec_o
);
  localparam int unsigned CNT_W = 2 * HALF_W;
  localparam int unsigned REC_W = CNT_W + WRAP_W + SEQ_W;

  logic [CNT_W-1:0]  cnt;
  logic [WRAP_W-1:0] ext;
  logic [SEQ_W-1:0]  seq_q, seq_d;
  logic [REC_W-1:0]  rec_q, rec_d;

  pdc_cascade_counter #(
    .HALF_W (HALF_W),
    .WRAP_W (WRAP_W)
  ) u_count (
    .clk    (clk),
    .rst_n  (rst_n),
    .inc_i  (inc_i),
    .cnt_o  (cnt),
    .wrap_o (ext)
  );

  always_comb begin
    seq_d = seq_q;
    rec_d = rec_q;
    if (cap_i) begin
      seq_d = seq_q + 1'b1;
      rec_d = {seq_d, ext, cnt};
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      seq_q <= '0;
      rec_q <= '0;
    end else begin
      seq_q <= seq_d;
      rec_q <= rec_d;
    end
  end

  assign rec_o = rec_q;

  // R5: each capture adds exactly one to the sequence
  p_seq_step_r5: assert property (@(posedge clk) disable iff (!rst_n)
    cap_i |=> (seq_q == SEQ_W'($past(seq_q) + 1'b1)));

  // R4: the latched count matches the counter pair of the capture cycle
  p_coherent_r4: assert property (@(posedge clk) disable iff (!rst_n)
    cap_i |=> (rec_q[CNT_W-1:0] == $past(cnt)));

  // R5: the record holds between captures
  p_rec_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !cap_i |=> $stable(rec_q));
endmodule

// File: rtl/gated_dual_counter.sv
module gated_dual_counter #(
  parameter int unsigned HALF_W     = 16,
  parameter int unsigned WRAP_W     = 16,
  parameter int unsigned SEQ_W      = 16,
  parameter int unsigned SAMPLE_DIV = 4,
  parameter int unsigned FILT_N     = 4
) (
  input  logic                                clk,
  input  logic                                rst_n,
  input  logic                                sig_in,
  input  logic                                pulse_in,
  input  logic                                rec_ready,
  output logic                                rec_valid,
  output logic                                rec_path,
  output logic [2*HALF_W+WRAP_W+SEQ_W-1:0]    rec_data,
  output logic                                overrun
);
  import pdc_pkg::*;

  localparam int unsigned CNT_W = 2 * HALF_W;
  localparam int unsigned REC_W = CNT_W + WRAP_W + SEQ_W;

  // reset: asserts at once, releases through two flops
  logic [1:0] rst_sync_q;
  logic       rst_n_s;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_n_s = rst_sync_q[1];

  // unknown-signal edge detect
  logic sig_q, sig_rise;

  always_ff @(posedge clk or negedge rst_n_s) begin
    if (!rst_n_s) sig_q <= 1'b0;
    else          sig_q <= sig_in;
  end
  assign sig_rise = sig_in & ~sig_q;

  // pulse qualification
  logic cap;

  pdc_pulse_filter #(
    .SAMPLE_DIV (SAMPLE_DIV),
    .FILT_N     (FILT_N)
  ) u_filter (
    .clk      (clk),
    .rst_n    (rst_n_s),
    .pulse_in (pulse_in),
    .rise_o   (cap)
  );

  // two capture paths
  logic [NUM_PATHS-1:0] path_inc;
  logic [REC_W-1:0]     path_rec [NUM_PATHS];

  for (genvar g = 0; g < NUM_PATHS; g++) begin : g_path
    if (g == int'(PATH_EVT)) begin : g_evt
      assign path_inc[g] = sig_rise;
    end else begin : g_ref
      assign path_inc[g] = 1'b1;
    end

    pdc_capture_path #(
      .HALF_W (HALF_W),
      .WRAP_W (WRAP_W),
      .SEQ_W  (SEQ_W)
    ) u_path (
      .clk   (clk),
      .rst_n (rst_n_s),
      .inc_i (path_inc[g]),
      .cap_i (cap),
      .rec_o (path_rec[g])
    );
  end

  // record emitter: slot 0 event, slot 1 reference
  logic [1:0] emit_q, emit_d;
  logic       ovr_q, ovr_d;

  always_comb begin
    emit_d = {emit_q[0], cap};
    ovr_d  = ovr_q | ((|emit_q) & ~rec_ready);
  end

  always_ff @(posedge clk or negedge rst_n_s) begin
    if (!rst_n_s) begin
      emit_q <= 2'b00;
      ovr_q  <= 1'b0;
    end else begin
      emit_q <= emit_d;
      ovr_q  <= ovr_d;
    end
  end

  assign rec_valid = |emit_q;
  assign rec_path  = emit_q[1];
  assign rec_data  = emit_q[1] ? path_rec[int'(PATH_REF)] : path_rec[int'(PATH_EVT)];
  assign overrun   = ovr_q;

  // R8: event record is always followed by the reference record
  p_pair_order_r8: assert property (@(posedge clk) disable iff (!rst_n_s)
    (rec_valid && (rec_path == PATH_EVT)) |=> (rec_valid && (rec_path == PATH_REF)));

  // R8: never two slots busy at once
  p_one_slot_r8: assert property (@(posedge clk) disable iff (!rst_n_s)
    $onehot0(emit_q));

  // R9: overrun, once set, stays set
  p_overrun_sticky_r9: assert property (@(posedge clk) disable iff (!rst_n_s)
    overrun |=> overrun);

  // R9: a refused offer raises overrun
  p_overrun_set_r9: assert property (@(posedge clk) disable iff (!rst_n_s)
    (rec_valid && !rec_ready) |=> overrun);
endmodule

// File: tb/gated_dual_counter_bench.sv
`timescale 1ns/1ps
module gated_dual_counter_bench;
  localparam int HW = 4;
  localparam int WW = 8;
  localparam int SW = 8;
  localparam int SD = 4;
  localparam int FN = 3;
  localparam int CW = 2 * HW;
  localparam int EW = CW + WW;
  localparam int RW = EW + SW;
  localparam int NSLOT = 8;
  localparam int EDGE_TAB [NSLOT] = '{3, 0, 17, 1, 150, 120, 16, 9};

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic sig_in = 1'b0;
  logic pulse_in = 1'b0;
  logic rec_ready = 1'b1;
  logic rec_valid, rec_path, overrun;
  logic [RW-1:0] rec_data;

  always #2.5 clk = ~clk;

  gated_dual_counter #(
    .HALF_W (HW), .WRAP_W (WW), .SEQ_W (SW), .SAMPLE_DIV (SD), .FILT_N (FN)
  ) u_gated_dual_counter (
    .clk (clk), .rst_n (rst_n), .sig_in (sig_in), .pulse_in (pulse_in),
    .rec_ready (rec_ready), .rec_valid (rec_valid), .rec_path (rec_path),
    .rec_data (rec_data), .overrun (overrun)
  );

  int n_chk = 0;
  int n_bad = 0;
  bit done = 0;

  logic [RW-1:0] mon_d [0:127];
  logic          mon_p [0:127];
  int mon_n = 0;
  int drop_n = 0;

  always @(negedge clk) begin
    if (rec_valid === 1'b1) begin
      if (rec_ready) begin
        if (mon_n < 128) begin
          mon_d[mon_n] = rec_data;
          mon_p[mon_n] = rec_path;
        end
        mon_n++;
      end else begin
        drop_n++;
      end
    end
  end

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic cyc(input int n);
    repeat (n) begin @(posedge clk); #1; end
  endtask

  task automatic edges(input int n);
    for (int i = 0; i < n; i++) begin
      sig_in = 1'b1; cyc(2); sig_in = 1'b0; cyc(2);
    end
  endtask

  task automatic pulse_slot(input int n_edges, output int len);
    pulse_in = 1'b1; cyc(40);
    pulse_in = 1'b0; cyc(20);
    edges(n_edges);
    cyc(20);
    len = 80 + 4 * n_edges;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual running expected finished");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    int total;
    int prev_len;
    int base;
    int drop0;
    logic [EW-1:0] prev_ref;
    logic [EW-1:0] diff;
    logic [EW-1:0] ev;

    total = 0; prev_len = 0; prev_ref = '0;

    // R10: reset state
    cyc(3);
    chk("R10 valid in reset", 64'(rec_valid), 64'd0);
    chk("R10 overrun in reset", 64'(overrun), 64'd0);
    chk("R10 data in reset", 64'(rec_data), 64'd0);
    rst_n = 1'b1;
    cyc(4);

    // table-driven pulses
    for (int k = 0; k < NSLOT; k++) begin
      int len;
      base = mon_n;
      pulse_slot(EDGE_TAB[k], len);
      chk("R7 one pair per pulse", 64'(mon_n - base), 64'd2);
      chk("R8 event first", 64'(mon_p[base]), 64'd0);
      chk("R8 reference second", 64'(mon_p[base+1]), 64'd1);
      chk("R1 event count", 64'(mon_d[base][CW-1:0]), 64'(total % 256));
      chk("R2 event extension", 64'(mon_d[base][EW-1:CW]), 64'(total / 256));
      chk("R5 event seq", 64'(mon_d[base][RW-1:EW]), 64'(k + 1));
      chk("R5 reference seq", 64'(mon_d[base+1][RW-1:EW]), 64'(k + 1));
      if (k > 0) begin
        diff = mon_d[base+1][EW-1:0] - prev_ref;
        chk("R3 reference spacing", 64'(diff), 64'(prev_len));
      end
      prev_ref = mon_d[base+1][EW-1:0];
      prev_len = len;
      total += EDGE_TAB[k];
    end

    // R6: short pulse is rejected
    base = mon_n;
    pulse_in = 1'b1; cyc(5); pulse_in = 1'b0; cyc(60);
    chk("R6 short pulse ignored", 64'(mon_n - base), 64'd0);

    // R4: edges running through the capture
    base = mon_n;
    for (int i = 0; i < 10; i++) begin
      sig_in = 1'b1;
      if (i == 0) pulse_in = 1'b1;
      cyc(2); sig_in = 1'b0; cyc(2);
    end
    pulse_in = 1'b0; cyc(40);
    chk("R7 pair on busy pulse", 64'(mon_n - base), 64'd2);
    ev = mon_d[base][EW-1:0];
    chk("R4 untorn lower bound", 64'(ev >= EW'(total)), 64'd1);
    chk("R4 untorn upper bound", 64'(ev <= EW'(total + 10)), 64'd1);
    chk("R5 seq after rejected pulse", 64'(mon_d[base][RW-1:EW]), 64'd9);
    total += 10;

    // R9: refused records
    rec_ready = 1'b0;
    base = mon_n; drop0 = drop_n;
    pulse_in = 1'b1; cyc(40); pulse_in = 1'b0; cyc(40);
    chk("R9 overrun set", 64'(overrun), 64'd1);
    chk("R9 both dropped", 64'(drop_n - drop0), 64'd2);
    chk("R9 nothing accepted", 64'(mon_n - base), 64'd0);
    rec_ready = 1'b1; cyc(10);
    chk("R9 overrun sticky", 64'(overrun), 64'd1);
    base = mon_n;
    pulse_in = 1'b1; cyc(40); pulse_in = 1'b0; cyc(40);
    chk("R5 seq counts dropped pulse", 64'(mon_d[base][RW-1:EW]), 64'd11);
    chk("R1 count after drop", 64'(mon_d[base][EW-1:0]), 64'(total));

    // R10: reset mid-run
    rst_n = 1'b0; cyc(2);
    chk("R10 overrun cleared", 64'(overrun), 64'd0);
    chk("R10 valid low", 64'(rec_valid), 64'd0);
    rst_n = 1'b1; cyc(4);
    edges(5);
    base = mon_n;
    pulse_in = 1'b1; cyc(40); pulse_in = 1'b0; cyc(40);
    chk("R10 seq restarts", 64'(mon_d[base][RW-1:EW]), 64'd1);
    chk("R10 count restarts", 64'(mon_d[base][EW-1:0]), 64'd5);
    chk("R10 reference seq restarts", 64'(mon_d[base+1][RW-1:EW]), 64'd1);
    chk("R10 overrun stays clear", 64'(overrun), 64'd0);

    done = 1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule